// File: doc/BRIEF.md
# Serial Character Buffer with Threshold Interrupts

This block sits between the register side of a serial port and its shift engines. It keeps one queue for characters going out and one for characters coming in. With buffering switched on, each queue holds `DEPTH` characters (eight by default). With buffering switched off, each queue acts as a single holding register. The host pushes transmit characters and pops receive characters. The engines pop transmit characters and push receive characters. Every strobe is a single-cycle pulse, and the data travels beside it.

One control write loads five things at once: the buffering enable, both threshold codes and both interrupt enables. Each interrupt request is a registered level. The receive request follows how many entries are occupied. The transmit request follows how many entries are free. A change of the buffering enable empties both queues. A receive character that arrives while the receive queue is full is dropped, and a sticky overrun flag records the loss.

Top module: `serial_char_buffer`

## Requirements
- R1: After reset, buffering is off, both queues are empty (`tx_empty`=1, `rx_empty`=1, `tx_full`=0, `rx_full`=0), and `rx_overrun`, `tx_irq` and `rx_irq` are all 0.
- R2: With buffering on, each queue holds up to 8 characters in first-in first-out order. The full flag is set at 8 entries and the empty flag at 0 entries. A pop from an empty queue has no effect. A push in the same cycle as a pop on a full queue is dropped. All flags and the head data reflect an accepted strobe one clock after it.
- R3: With buffering off, each queue holds one character: it is full after one accepted push and empty after one pop.
- R4: With buffering on, `rx_irq` is 1 while the receive occupancy is at least the level picked by the 3-bit receive code. Code 0 selects 1 entry, 1 selects 2, 2 selects 4, 3 selects 6, 4 selects 7, and codes 5 to 7 select 4. The request is registered and changes in the same cycle as the flags.
- R5: With buffering on, `tx_irq` is 1 while the transmit free count (8 minus occupancy) is at least the level picked by the transmit code. The levels are the same as in R4: codes 0..4 select 1, 2, 4, 6 and 7, and codes 5..7 select 4. Code 4 therefore fires only when at most one character is queued.
- R6: With buffering off, `rx_irq` is 1 while the receive register holds a character and `tx_irq` is 1 while the transmit register is empty, whatever the threshold codes are.
- R7: Each request is forced to 0 while its interrupt enable (`cfg_rx_ie`, `cfg_tx_ie`, as last written) is 0.
- R8: A receive push into a full receive queue leaves the queue contents unchanged and sets `rx_overrun`. The flag stays set until a cycle with `ovr_clr`=1 and no new overrun; if both happen in the same cycle, the set wins.
- R9: A transmit push into a full transmit queue is ignored: the occupancy and the order of the queued characters do not change.
- R10: A control write that changes the buffering enable empties both queues and drops any push or pop in that cycle. A control write that keeps the same enable value leaves both queues untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe; loads all cfg_* fields |
| cfg_buf_en | input | 1 | Buffering enable (1 = DEPTH-deep queues) |
| cfg_rx_sel | input | 3 | Receive threshold code |
| cfg_tx_sel | input | 3 | Transmit threshold code |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| host_tx_push | input | 1 | Host writes a transmit character |
| host_tx_data | input | DW | Transmit character from the host |
| host_rx_pop | input | 1 | Host takes the head receive character |
| host_rx_data | output | DW | Head of the receive queue |
| eng_tx_pop | input | 1 | Transmit engine takes the head character |
| eng_tx_data | output | DW | Head of the transmit queue |
| eng_rx_push | input | 1 | Receive engine delivers a character |
| eng_rx_data | input | DW | Received character |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_irq | output | 1 | Transmit interrupt request (level) |
| rx_irq | output | 1 | Receive interrupt request (level) |

## Verification
The bench walks every threshold code, including the three unused codes, through each occupancy. A wrong level table shows up as a request that moves one entry early or late. It also checks that the transmit request follows free entries, not occupied ones; a design that counts the wrong way fires on a full queue. Pushes into full queues check that a transmit push changes nothing and that a lost receive character sets the overrun flag and keeps it set until it is cleared. Mode toggles and control rewrites check that only a real change of the enable empties the queues. Long random mixes of strobes, including simultaneous push and pop at the full and empty edges, are checked against a reference queue model.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned SEL_W = 3;

  // threshold level in entries for a 3-bit selection code
  function automatic int unsigned sel_level(input logic [SEL_W-1:0] code,
                                            input int unsigned depth);
    case (code)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction
endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          single,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          full,
  output logic          empty,
  output logic          push_drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap       = single ? CW'(1) : CW'(DEPTH);
  assign full      = (count == cap);
  assign empty     = (count == '0);
  assign do_push   = push && !full && !flush;
  assign do_pop    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign count_nxt = flush ? '0 : (count + CW'(do_push) - CW'(do_pop));
  assign head_data = mem[rd_ptr];

  // storage without reset so a distributed RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
    end
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  // R2 / R3: occupancy never exceeds the capacity of the current mode
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= cap);

  // R10: a flush leaves the queue empty
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

  // R9: push into a full queue without pop keeps occupancy
  p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/sbuf_level.sv
module sbuf_level #(
  parameter int unsigned DEPTH      = 8,
  parameter bit          COUNT_FREE = 1'b0,
  localparam int unsigned CW        = $clog2(DEPTH) + 1
) (
  input  logic                      buf_en,
  input  logic [sbuf_pkg::SEL_W-1:0] sel,
  input  logic                      ie,
  input  logic [CW-1:0]             count,
  output logic                      hit
);
  logic [CW-1:0] lvl, cap, metric;

  assign cap = buf_en ? CW'(DEPTH) : CW'(1);
  assign lvl = buf_en ? CW'(sbuf_pkg::sel_level(sel, DEPTH)) : CW'(1);

  generate
    if (COUNT_FREE) begin : g_free
      assign metric = cap - count;
    end else begin : g_used
      assign metric = count;
    end
  endgenerate

  assign hit = ie && (metric >= lvl);
endmodule

// File: rtl/serial_char_buffer.sv
module serial_char_buffer #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      cfg_buf_en,
  input  logic [sbuf_pkg::SEL_W-1:0] cfg_rx_sel,
  input  logic [sbuf_pkg::SEL_W-1:0] cfg_tx_sel,
  input  logic                      cfg_rx_ie,
  input  logic                      cfg_tx_ie,
  input  logic                      ovr_clr,
  input  logic                      host_tx_push,
  input  logic [DW-1:0]             host_tx_data,
  input  logic                      host_rx_pop,
  output logic [DW-1:0]             host_rx_data,
  input  logic                      eng_tx_pop,
  output logic [DW-1:0]             eng_tx_data,
  input  logic                      eng_rx_push,
  input  logic [DW-1:0]             eng_rx_data,
  output logic                      tx_full,
  output logic                      tx_empty,
  output logic                      rx_full,
  output logic                      rx_empty,
  output logic                      rx_overrun,
  output logic                      tx_irq,
  output logic                      rx_irq
);
  import sbuf_pkg::*;

  logic             en_q, en_n;
  logic [SEL_W-1:0] rxsel_q, rxsel_n, txsel_q, txsel_n;
  logic             rxie_q, rxie_n, txie_q, txie_n;
  logic             flush;
  logic [CW-1:0]    tx_cnt, tx_cnt_n, rx_cnt, rx_cnt_n;
  logic             tx_drop, rx_drop;
  logic             tx_hit, rx_hit;

  assign flush   = cfg_we && (cfg_buf_en != en_q);
  assign en_n    = cfg_we ? cfg_buf_en : en_q;
  assign rxsel_n = cfg_we ? cfg_rx_sel : rxsel_q;
  assign txsel_n = cfg_we ? cfg_tx_sel : txsel_q;
  assign rxie_n  = cfg_we ? cfg_rx_ie  : rxie_q;
  assign txie_n  = cfg_we ? cfg_tx_ie  : txie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      rxsel_q <= '0;
      txsel_q <= '0;
      rxie_q  <= 1'b0;
      txie_q  <= 1'b0;
    end else begin
      en_q    <= en_n;
      rxsel_q <= rxsel_n;
      txsel_q <= txsel_n;
      rxie_q  <= rxie_n;
      txie_q  <= txie_n;
    end
  end

  sbuf_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .single(!en_q), .flush(flush),
    .push(host_tx_push), .push_data(host_tx_data), .pop(eng_tx_pop),
    .head_data(eng_tx_data), .count(tx_cnt), .count_nxt(tx_cnt_n),
    .full(tx_full), .empty(tx_empty), .push_drop(tx_drop));

  sbuf_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .single(!en_q), .flush(flush),
    .push(eng_rx_push), .push_data(eng_rx_data), .pop(host_rx_pop),
    .head_data(host_rx_data), .count(rx_cnt), .count_nxt(rx_cnt_n),
    .full(rx_full), .empty(rx_empty), .push_drop(rx_drop));

  // requests evaluated on next-state values, so they settle with the flags
  sbuf_level #(.DEPTH(DEPTH), .COUNT_FREE(1'b1)) u_txlvl (
    .buf_en(en_n), .sel(txsel_n), .ie(txie_n), .count(tx_cnt_n), .hit(tx_hit));

  sbuf_level #(.DEPTH(DEPTH), .COUNT_FREE(1'b0)) u_rxlvl (
    .buf_en(en_n), .sel(rxsel_n), .ie(rxie_n), .count(rx_cnt_n), .hit(rx_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq     <= 1'b0;
      rx_irq     <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      tx_irq     <= tx_hit;
      rx_irq     <= rx_hit;
      rx_overrun <= (rx_overrun && !ovr_clr) || rx_drop;
    end
  end

  // R4: every receive level is at least one entry
  p_rx_irq_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> !rx_empty);

  // R6: single-register transmit request only when the register is empty
  p_tx_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && !en_q) |-> tx_empty);

  // R7: a masked direction never requests
  p_irq_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (!rxie_q |-> !rx_irq) and (!txie_q |-> !tx_irq));

  // R8: overrun stays set without a clear
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !ovr_clr) |=> rx_overrun);

  // R10: a mode change leaves both queues empty
  p_mode_flush_r10: assert property (@(posedge clk) disable iff (rst)
    (en_q != $past(en_q)) |-> (tx_empty && rx_empty));
endmodule

// File: tb/serial_char_buffer_tb_top.sv
module serial_char_buffer_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_buf_en = 0, cfg_rx_ie = 0, cfg_tx_ie = 0, ovr_clr = 0;
  logic [2:0] cfg_rx_sel = 0, cfg_tx_sel = 0;
  logic host_tx_push = 0, host_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [DW-1:0] host_tx_data = 0, eng_rx_data = 0;
  logic [DW-1:0] host_rx_data, eng_tx_data;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_overrun, tx_irq, rx_irq;

  int checks = 0, errors = 0;

  // reference model
  logic m_en = 0, m_rxie = 0, m_txie = 0, m_ovr = 0;
  int   m_rxsel = 0, m_txsel = 0;
  int   m_txc = 0, m_rxc = 0;
  logic [DW-1:0] m_txq [DEPTH];
  logic [DW-1:0] m_rxq [DEPTH];

  always #5 clk = ~clk;

  serial_char_buffer #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_buf_en(cfg_buf_en),
    .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel), .cfg_rx_ie(cfg_rx_ie),
    .cfg_tx_ie(cfg_tx_ie), .ovr_clr(ovr_clr), .host_tx_push(host_tx_push),
    .host_tx_data(host_tx_data), .host_rx_pop(host_rx_pop),
    .host_rx_data(host_rx_data), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
    .tx_irq(tx_irq), .rx_irq(rx_irq));

  function automatic int lvl_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 7;
      default: return 4;
    endcase
  endfunction

  function automatic int cap_of();
    return m_en ? DEPTH : 1;
  endfunction

  function automatic logic exp_rx_irq();
    int l = m_en ? lvl_of(m_rxsel) : 1;
    return m_rxie && (m_rxc >= l);
  endfunction

  function automatic logic exp_tx_irq();
    int l = m_en ? lvl_of(m_txsel) : 1;
    return m_txie && ((cap_of() - m_txc) >= l);
  endfunction

  task automatic cmp(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  task automatic model_edge();
    logic flush, tpush, tpop, rpush, rpop, rdrop;
    int cap;
    cap   = cap_of();
    flush = cfg_we && (cfg_buf_en != m_en);
    tpush = host_tx_push && (m_txc < cap) && !flush;
    tpop  = eng_tx_pop && (m_txc > 0) && !flush;
    rpush = eng_rx_push && (m_rxc < cap) && !flush;
    rpop  = host_rx_pop && (m_rxc > 0) && !flush;
    rdrop = eng_rx_push && (m_rxc == cap) && !flush;
    if (flush) begin
      m_txc = 0;
      m_rxc = 0;
    end else begin
      if (tpop) begin
        for (int i = 0; i < DEPTH - 1; i++) m_txq[i] = m_txq[i+1];
        m_txc--;
      end
      if (tpush) begin m_txq[m_txc] = host_tx_data; m_txc++; end
      if (rpop) begin
        for (int i = 0; i < DEPTH - 1; i++) m_rxq[i] = m_rxq[i+1];
        m_rxc--;
      end
      if (rpush) begin m_rxq[m_rxc] = eng_rx_data; m_rxc++; end
    end
    m_ovr = (m_ovr && !ovr_clr) || rdrop;
    if (cfg_we) begin
      m_en = cfg_buf_en; m_rxsel = cfg_rx_sel; m_txsel = cfg_tx_sel;
      m_rxie = cfg_rx_ie; m_txie = cfg_tx_ie;
    end
  endtask

  task automatic compare_all();
    string ft = m_en ? "R2" : "R3";
    string it = m_en ? "R4" : "R6";
    string tt = m_en ? "R5" : "R6";
    cmp(ft, "tx_full", tx_full, m_txc == cap_of());
    cmp(ft, "tx_empty", tx_empty, m_txc == 0);
    cmp(ft, "rx_full", rx_full, m_rxc == cap_of());
    cmp(ft, "rx_empty", rx_empty, m_rxc == 0);
    if (m_txc > 0) cmp("R2", "eng_tx_data", eng_tx_data, m_txq[0]);
    if (m_rxc > 0) cmp("R2", "host_rx_data", host_rx_data, m_rxq[0]);
    cmp(it, "rx_irq", rx_irq, exp_rx_irq());
    cmp(tt, "tx_irq", tx_irq, exp_tx_irq());
    cmp("R8", "rx_overrun", rx_overrun, m_ovr);
  endtask

  // one clock: inputs already set at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
    @(negedge clk);
    cfg_we = 0; ovr_clr = 0; host_tx_push = 0; host_rx_pop = 0;
    eng_tx_pop = 0; eng_rx_push = 0;
  endtask

  task automatic write_cfg(logic en, int rs, int ts, logic rie, logic tie);
    cfg_we = 1; cfg_buf_en = en; cfg_rx_sel = 3'(rs); cfg_tx_sel = 3'(ts);
    cfg_rx_ie = rie; cfg_tx_ie = tie;
    step();
  endtask

  task automatic tx_push(logic [DW-1:0] d);
    host_tx_push = 1; host_tx_data = d; step();
  endtask

  task automatic rx_push(logic [DW-1:0] d);
    eng_rx_push = 1; eng_rx_data = d; step();
  endtask

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C01));
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    cmp("R1", "tx_empty", tx_empty, 1);
    cmp("R1", "rx_empty", rx_empty, 1);
    cmp("R1", "tx_full", tx_full, 0);
    cmp("R1", "rx_full", rx_full, 0);
    cmp("R1", "irqs", {rx_overrun, tx_irq, rx_irq}, 0);

    // R3 / R6: single-register mode
    write_cfg(0, 4, 4, 1, 1);
    cmp("R6", "tx_irq empty", tx_irq, 1);
    tx_push(8'hA1);
    cmp("R3", "tx_full one", tx_full, 1);
    cmp("R6", "tx_irq held", tx_irq, 0);
    rx_push(8'h5C);
    cmp("R3", "rx_full one", rx_full, 1);
    cmp("R6", "rx_irq one", rx_irq, 1);
    rx_push(8'h77);
    cmp("R8", "overrun set", rx_overrun, 1);
    cmp("R8", "data kept", host_rx_data, 8'h5C);
    host_rx_pop = 1; step();
    cmp("R3", "rx_empty after pop", rx_empty, 1);
    cmp("R8", "overrun sticky", rx_overrun, 1);
    ovr_clr = 1; step();
    cmp("R8", "overrun cleared", rx_overrun, 0);
    // R10: same enable keeps contents
    write_cfg(0, 2, 2, 1, 1);
    cmp("R10", "no flush tx_full", tx_full, 1);
    write_cfg(1, 0, 0, 1, 1);
    cmp("R10", "flush tx_empty", tx_empty, 1);

    // R2 / R9: eight-deep order and full behaviour
    for (int k = 0; k < DEPTH; k++) tx_push(8'(8'h10 + k));
    cmp("R2", "tx_full at 8", tx_full, 1);
    tx_push(8'hEE);
    for (int k = 0; k < DEPTH; k++) begin
      cmp("R9", "tx order", eng_tx_data, 8'h10 + k);
      eng_tx_pop = 1; step();
    end
    cmp("R9", "tx_empty after 8", tx_empty, 1);
    eng_tx_pop = 1; step();
    cmp("R2", "pop empty ignored", tx_empty, 1);

    // R4 / R5: walk every code through every occupancy
    for (int c = 0; c < 8; c++) begin
      write_cfg(0, c, c, 1, 1);
      write_cfg(1, c, c, 1, 1);
      for (int k = 1; k <= DEPTH; k++) begin
        rx_push(8'(k)); 
        cmp("R4", "rx_irq level", rx_irq, k >= lvl_of(c));
        tx_push(8'(k));
        cmp("R5", "tx_irq level", tx_irq, (DEPTH - k) >= lvl_of(c));
      end
    end
    // R7: masked
    write_cfg(1, 0, 0, 0, 0);
    cmp("R7", "rx masked", rx_irq, 0);
    cmp("R7", "tx masked", tx_irq, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        cfg_we = 1;
        cfg_buf_en = ($urandom_range(0, 3) != 0);
        cfg_rx_sel = 3'($urandom_range(0, 7));
        cfg_tx_sel = 3'($urandom_range(0, 7));
        cfg_rx_ie = ($urandom_range(0, 4) != 0);
        cfg_tx_ie = ($urandom_range(0, 4) != 0);
      end
      host_tx_push = $urandom_range(0, 1);
      host_tx_data = 8'($urandom);
      eng_tx_pop   = ($urandom_range(0, 2) == 0);
      eng_rx_push  = $urandom_range(0, 1);
      eng_rx_data  = 8'($urandom);
      host_rx_pop  = ($urandom_range(0, 2) == 0);
      ovr_clr      = ($urandom_range(0, 15) == 0);
      step();
    end

    summary();
    $finish;
  end
endmodule